// File: doc/BRIEF.md
# Two-Level Block Protection Manager

This block keeps two bits for each of the erasable blocks of a memory array: a stored protect bit and a lock bit. Protect, unprotect and lock requests arrive on a single command port, one per cycle, and take effect at the next clock edge. An active-low write-protect input, `wp_n`, decides whether the lock layer is enforced. While `wp_n` is high, lock bits are ignored and any block may be protected or unprotected. While `wp_n` is low, a locked block is treated as protected and its stored protect bit cannot be changed.

The effective protection of a block is its stored protect bit ORed with its lock bit, and the lock bit only counts while `wp_n` is low. The stored bit is never overwritten by the lock layer. So when `wp_n` rises, each locked block shows the protect value it held before again.

A program or erase controller asks about a block on the query port and receives a deny flag combinationally in the same cycle. A separate status port returns a two-bit readout for any block.

Top module: `prot_lock_mgr`

## Requirements
- R1: Reset (`rst_n` low) leaves every block with its stored protect bit set and its lock bit clear, so every in-range status reads 2'b01.
- R2: With `wp_n` high, a protect command (`cmd_op` = 2'b01) sets and an unprotect command (`cmd_op` = 2'b10) clears the stored protect bit of `cmd_blk`. This holds whether or not that block is locked, and the new value is visible after the next rising clock edge.
- R3: A lock command (`cmd_op` = 2'b11) sets the lock bit of `cmd_blk` at the next edge whatever the level of `wp_n`. Only reset clears a lock bit; an unprotect command does not.
- R4: With `wp_n` low, a locked block is effectively protected whatever its stored protect bit holds.
- R5: With `wp_n` low, protect and unprotect commands aimed at a locked block leave its stored protect bit unchanged.
- R6: With `wp_n` low, protect and unprotect commands still change the protect bit of unlocked blocks.
- R7: When `wp_n` returns high, a locked block's effective protection equals the stored protect bit it held before it was locked, including any change made while `wp_n` was high.
- R8: `stat_out` for block `stat_blk` carries the effective protection in bit 0 and the lock bit in bit 1. It is combinational from the current state.
- R9: `qry_deny` is high in the same cycle as `qry_valid` exactly when the queried block is effectively protected. It is low whenever `qry_valid` is low.
- R10: A block index of 71 or above is out of range. Commands at it change no state, `stat_out` reads 2'b00 for it, and a valid query at it is denied. `cmd_op` = 2'b00 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin, low enforces the lock layer |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 protect, 10 unprotect, 11 lock |
| cmd_blk | input | 7 | Block index of the command |
| qry_valid | input | 1 | Program/erase permission query strobe |
| qry_blk | input | 7 | Block index of the query |
| qry_deny | output | 1 | Query refused, same cycle |
| stat_blk | input | 7 | Block index for status readout |
| stat_out | output | 2 | Bit 1 locked, bit 0 effectively protected |

## Verification
A wrong stored protect bit can stay hidden while its block is locked under a low `wp_n`. It shows up only once `wp_n` rises, and then at once on `stat_out[0]` and on `qry_deny` for that block. A lock bit that clears or sets on the wrong command shows up on `stat_out[1]` in the cycle after that command. Because of this, the bench reads the status of every block repeatedly across `wp_n` toggles, not only the block that was just addressed.

// File: rtl/prot_lock_mgr.sv
module prot_lock_mgr #(
  parameter int NBLK = 71,
  localparam int BW = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [BW-1:0] cmd_blk,
  input  logic          qry_valid,
  input  logic [BW-1:0] qry_blk,
  output logic          qry_deny,
  input  logic [BW-1:0] stat_blk,
  output logic [1:0]    stat_out
);

  localparam logic [1:0] OP_PROT   = 2'b01;
  localparam logic [1:0] OP_UNPROT = 2'b10;
  localparam logic [1:0] OP_LOCK   = 2'b11;

  logic [NBLK-1:0] prot_q, lock_q, eff;
  logic cmd_ok, qry_ok, stat_ok, frozen;

  assign eff     = prot_q | (lock_q & {NBLK{~wp_n}});
  assign cmd_ok  = cmd_valid && (int'(cmd_blk) < NBLK);
  assign qry_ok  = int'(qry_blk) < NBLK;
  assign stat_ok = int'(stat_blk) < NBLK;
  assign frozen  = cmd_ok && !wp_n && lock_q[cmd_blk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= '1;
      lock_q <= '0;
    end else if (cmd_ok) begin
      case (cmd_op)
        OP_PROT:   if (!frozen) prot_q[cmd_blk] <= 1'b1;
        OP_UNPROT: if (!frozen) prot_q[cmd_blk] <= 1'b0;
        OP_LOCK:   lock_q[cmd_blk] <= 1'b1;
        default:   ;
      endcase
    end
  end

  assign stat_out = stat_ok ? {lock_q[stat_blk], eff[stat_blk]} : 2'b00;
  assign qry_deny = qry_valid && (!qry_ok || eff[qry_blk]);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((&prot_q) && (lock_q == '0)));

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(lock_q) & ~lock_q) == '0));

  assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> (((prot_q ^ $past(prot_q)) & $past(lock_q)) == '0));

  assert_locked_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_ok && !wp_n && lock_q[qry_blk]) |-> qry_deny);

  assert_unprot_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && cmd_op == OP_UNPROT && wp_n) |=> !prot_q[$past(cmd_blk)]);

  assert_idle_query_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |-> !qry_deny);

endmodule

// File: tb/prot_lock_mgr_tb.sv
module prot_lock_mgr_tb;
  localparam int NBLK = 71;

  logic clk = 0, rst_n = 0, wp_n = 1;
  logic cmd_valid = 0, qry_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [6:0] cmd_blk = 0, qry_blk = 0, stat_blk = 0;
  logic qry_deny;
  logic [1:0] stat_out;

  bit m_prot[NBLK];
  bit m_lock[NBLK];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prot_lock_mgr u_dut (.clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_blk(cmd_blk), .qry_valid(qry_valid), .qry_blk(qry_blk),
    .qry_deny(qry_deny), .stat_blk(stat_blk), .stat_out(stat_out));

  function automatic bit exp_eff(int b);
    if (b >= NBLK) return 1'b1;
    return m_prot[b] | (m_lock[b] & ~wp_n);
  endfunction

  function automatic logic [1:0] exp_stat(int b);
    if (b >= NBLK) return 2'b00;
    return {m_lock[b], exp_eff(b)};
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NBLK; i++) begin m_prot[i] = 1; m_lock[i] = 0; end
  endtask

  task automatic do_cmd(logic [1:0] op, int b);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_blk = 7'(b);
    @(posedge clk);
    if (rst_n && b < NBLK) begin
      case (op)
        2'b01: if (wp_n || !m_lock[b]) m_prot[b] = 1;
        2'b10: if (wp_n || !m_lock[b]) m_prot[b] = 0;
        2'b11: m_lock[b] = 1;
        default: ;
      endcase
    end
    #1 cmd_valid = 0;
  endtask

  task automatic set_wp(logic v);
    @(negedge clk); wp_n = v;
  endtask

  task automatic look(string tag, int b);
    stat_blk = 7'(b); qry_blk = 7'(b); qry_valid = 1;
    #1;
    chk({tag, " stat R8"}, stat_out, exp_stat(b));
    chk({tag, " deny R9"}, qry_deny, exp_eff(b));
    qry_valid = 0;
    #1;
    chk({tag, " idle R9"}, qry_deny, 0);
  endtask

  task automatic sweep(string tag);
    for (int b = 0; b < NBLK; b++) begin
      stat_blk = 7'(b); #1;
      chk(tag, stat_out, exp_stat(b));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    sweep("R1 reset status");

    do_cmd(2'b10, 5); look("R2 unprotect", 5);
    do_cmd(2'b11, 5); look("R3 lock", 5);
    set_wp(0); look("R4 locked under wp", 5);
    do_cmd(2'b01, 5); do_cmd(2'b10, 5); look("R5 frozen", 5);
    do_cmd(2'b10, 9); look("R6 unlocked changes", 9);
    set_wp(1); look("R7 restore", 5);
    do_cmd(2'b01, 5); do_cmd(2'b10, 5); look("R2 locked wp high", 5);
    do_cmd(2'b10, 70); look("R2 top block", 70);
    do_cmd(2'b10, 71); look("R10 out of range", 71);
    do_cmd(2'b00, 0); look("R10 noop", 0);
    do_cmd(2'b10, 0); look("R3 unprotect keeps lock", 5);
    sweep("R10 no stray change");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) set_wp(~wp_n);
      do_cmd(2'($urandom_range(3)), $urandom_range(79));
      look("R2-rand", $urandom_range(79));
      look("R5-rand", $urandom_range(NBLK - 1));
      if (i % 500 == 499) sweep("R7 sweep");
    end

    @(negedge clk) rst_n = 0;
    @(posedge clk); model_reset();
    @(negedge clk) rst_n = 1;
    sweep("R3 lock cleared by reset R1");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule